// File: doc/BRIEF.md
# Product-Term Allocator with Shared and Chained Expanders

This block is the sum-of-products core of one logic-array slice holding 16 macrocells. Every macrocell owns five local product terms, each an AND of any chosen literals from the array inputs (true or complement) and from a pool of 16 feedback expanders. It also owns one extra expander term. That term is an AND over the array-input literals only. Its inverted value is fed back into the array, where any macrocell's local terms can use it as a literal.

Macrocells are split into two independent chains of eight. A macrocell can pull in the whole OR-bound group of up to three lower-numbered neighbours in its own chain, as one unbroken run, so one sum can reach 20 terms. A group that has been handed upward no longer feeds its owner's sum. Any of the first four local terms can be steered away from the OR to a register-control output instead: clear, preset, clock or clock enable. Illegal allocation settings raise a flag. The whole path is combinational and has no loop, because expander terms never see sum outputs.

Top module: `pt_alloc_block`

## Requirements
- R1: Array literal k is ordered as follows. For k < 2*N_IN, literal 2i is input i and literal 2i+1 is its complement. Literal 2*N_IN+m is expander m. Fuse bit `(m*PT_PER_MC+t)*LIT_W + k` adds literal k to local term t of macrocell m. A term is true when at least one fuse is set and every selected literal is 1. A term with no fuse set is 0.
- R2: With no borrowing, no lending and no steering, a macrocell's sum is the OR of its own five terms.
- R3: Expander m is the complement of an AND over the input literals selected by bits `m*2*N_IN + k` of `shx_fuse`. If no bit is selected, the AND is 0 and the expander is 1. Several macrocells may use the same expander at once.
- R4: A borrow count b in bits `[2m+1:2m]` of `borrow_cnt` ORs the OR-bound groups of macrocells m-1 down to m-b into sum m.
- R5: A group taken by a higher neighbour contributes nothing to its owner's sum.
- R6: Macrocells 0..7 and 8..15 form separate chains, and borrowing never crosses between them. A count larger than a macrocell's position in its chain sets `config_error`, and the run is then clipped at the chain's first macrocell.
- R7: If two macrocells take the same group, `config_error` is set.
- R8: Setting bit `4m+k` of `steer` removes local term k (k = 0..3) of macrocell m from every OR. That term then drives bit m of the control output k, where k is 0 clear, 1 preset, 2 clock, 3 clock enable. A control output whose term is not steered is 0.
- R9: With all-zero configuration, and with any legal borrow pattern, `config_error` is 0. An all-zero configuration gives all-zero sums and controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arr_in | input | N_IN | Array input signals |
| term_fuse | input | NUM_MC*PT_PER_MC*LIT_W | Literal-select mask per local term |
| shx_fuse | input | NUM_MC*2*N_IN | Literal-select mask per expander term |
| borrow_cnt | input | NUM_MC*BW | Per-macrocell count of neighbour groups taken |
| steer | input | NUM_MC*4 | Per-term steering to control outputs |
| sum_out | output | NUM_MC | Combinational sum per macrocell |
| ctl_clr | output | NUM_MC | Steered clear term per macrocell |
| ctl_pre | output | NUM_MC | Steered preset term per macrocell |
| ctl_clk | output | NUM_MC | Steered clock term per macrocell |
| ctl_ce | output | NUM_MC | Steered clock-enable term per macrocell |
| config_error | output | 1 | Illegal allocation detected |

## Verification
Single-term patterns that mix a true and a complemented literal show that the polarity ordering and the empty-term rule are right. Toggling the input then shows that the term follows the literals and is not stuck. An expander used by two macrocells in different chains shows the inversion and the sharing. Borrow patterns at the top of a chain, at the chain seam and with overlapping runs tell apart four cases: correct group transfer, the lender going quiet, the chain separation, and the two error causes. A steered term watched on both the sum and the control output shows that the term is moved, not copied.

// File: rtl/pta_pkg.sv
package pta_pkg;
   typedef enum logic [1:0] {
      CTL_CLR = 2'd0,
      CTL_PRE = 2'd1,
      CTL_CLK = 2'd2,
      CTL_CE  = 2'd3
   } ctl_kind_e;

   localparam int NUM_CTL = 4;
endpackage

// File: rtl/pta_pterm.sv
module pta_pterm #(
   parameter int W = 8
) (
   input  logic [W-1:0] lits,
   input  logic [W-1:0] mask,
   output logic         hit
);
   generate
      if (W < 1) begin : g_bad_w
         $error("pta_pterm: W must be at least 1");
      end
   endgenerate

   always_comb begin
      hit = (|mask) & (&(lits | ~mask));
   end
endmodule

// File: rtl/pta_chain.sv
module pta_chain #(
   parameter int CHAIN_LEN  = 8,
   parameter int MAX_BORROW = 3,
   localparam int BW = $clog2(MAX_BORROW + 1)
) (
   input  logic [CHAIN_LEN*BW-1:0]        borrow,
   output logic [CHAIN_LEN*CHAIN_LEN-1:0] take,
   output logic [CHAIN_LEN-1:0]           claimed,
   output logic                           err
);
   generate
      if (CHAIN_LEN < 2) begin : g_bad_len
         $error("pta_chain: a chain needs at least two macrocells");
      end
   endgenerate

   logic over;
   logic multi;

   always_comb begin
      int b;
      int lo;
      int cnt;
      take  = '0;
      over  = 1'b0;
      multi = 1'b0;
      claimed = '0;
      for (int i = 0; i < CHAIN_LEN; i++) begin
         b = int'(borrow[i*BW +: BW]);
         if (b > i || b > MAX_BORROW) over = 1'b1;
         lo = (b > i) ? 0 : i - b;
         for (int j = 0; j < CHAIN_LEN; j++) begin
            if (j < i && j >= lo) take[i*CHAIN_LEN + j] = 1'b1;
         end
      end
      for (int j = 0; j < CHAIN_LEN; j++) begin
         cnt = 0;
         for (int i = 0; i < CHAIN_LEN; i++) begin
            cnt = cnt + int'(take[i*CHAIN_LEN + j]);
         end
         claimed[j] = (cnt != 0);
         if (cnt > 1) multi = 1'b1;
      end
      err = over | multi;
   end

   // R7: a group taken by two borrowers must be flagged
   always_comb begin
      for (int j = 0; j < CHAIN_LEN; j++) begin
         int n;
         n = 0;
         for (int i = 0; i < CHAIN_LEN; i++) n = n + int'(take[i*CHAIN_LEN + j]);
         a_r7_double_claim: assert (n <= 1 || err);
      end
   end
endmodule

// File: rtl/pt_alloc_block.sv
module pt_alloc_block #(
   parameter int N_IN       = 8,
   parameter int NUM_MC     = 16,
   parameter int PT_PER_MC  = 5,
   parameter int CHAIN_LEN  = 8,
   parameter int MAX_BORROW = 3,
   localparam int LIT_W     = 2*N_IN + NUM_MC,
   localparam int BW        = $clog2(MAX_BORROW + 1)
) (
   input  logic [N_IN-1:0]                   arr_in,
   input  logic [NUM_MC*PT_PER_MC*LIT_W-1:0] term_fuse,
   input  logic [NUM_MC*2*N_IN-1:0]          shx_fuse,
   input  logic [NUM_MC*BW-1:0]              borrow_cnt,
   input  logic [NUM_MC*4-1:0]               steer,
   output logic [NUM_MC-1:0]                 sum_out,
   output logic [NUM_MC-1:0]                 ctl_clr,
   output logic [NUM_MC-1:0]                 ctl_pre,
   output logic [NUM_MC-1:0]                 ctl_clk,
   output logic [NUM_MC-1:0]                 ctl_ce,
   output logic                              config_error
);
   import pta_pkg::*;

   localparam int NUM_CHAIN = NUM_MC / CHAIN_LEN;
   localparam int IN_LIT_W  = 2*N_IN;

   generate
      if (NUM_MC % CHAIN_LEN != 0) begin : g_bad_chain
         $error("pt_alloc_block: NUM_MC must be a multiple of CHAIN_LEN");
      end
      if (PT_PER_MC < NUM_CTL + 1) begin : g_bad_pt
         $error("pt_alloc_block: need a term beyond the steerable ones");
      end
      if (MAX_BORROW >= CHAIN_LEN) begin : g_bad_borrow
         $error("pt_alloc_block: MAX_BORROW must be below CHAIN_LEN");
      end
   endgenerate

   // literal vector: input true/complement pairs, then expander feedback
   logic [IN_LIT_W-1:0] in_lits;
   logic [NUM_MC-1:0]   shx_val;
   logic [LIT_W-1:0]    lits;

   always_comb begin
      for (int i = 0; i < N_IN; i++) begin
         in_lits[2*i]   = arr_in[i];
         in_lits[2*i+1] = ~arr_in[i];
      end
      lits = {shx_val, in_lits};
   end

   // shareable expanders: inputs only, so no loop through sums
   genvar gm, gt, gc;
   generate
      for (gm = 0; gm < NUM_MC; gm++) begin : g_shx
         logic and_hit;
         pta_pterm #(.W(IN_LIT_W)) u_term (
            .lits (in_lits),
            .mask (shx_fuse[gm*IN_LIT_W +: IN_LIT_W]),
            .hit  (and_hit)
         );
         assign shx_val[gm] = ~and_hit;
      end
   endgenerate

   // local terms and each macrocell's OR-bound group
   logic [PT_PER_MC-1:0] hits [NUM_MC];
   logic [NUM_MC-1:0]    grp;

   generate
      for (gm = 0; gm < NUM_MC; gm++) begin : g_mc_terms
         for (gt = 0; gt < PT_PER_MC; gt++) begin : g_pt
            pta_pterm #(.W(LIT_W)) u_term (
               .lits (lits),
               .mask (term_fuse[(gm*PT_PER_MC + gt)*LIT_W +: LIT_W]),
               .hit  (hits[gm][gt])
            );
         end
         always_comb begin
            logic [PT_PER_MC-1:0] keep;
            keep = '1;
            for (int k = 0; k < NUM_CTL; k++) keep[k] = ~steer[gm*NUM_CTL + k];
            grp[gm] = |(hits[gm] & keep);
         end
         assign ctl_clr[gm] = steer[gm*NUM_CTL + int'(CTL_CLR)] & hits[gm][int'(CTL_CLR)];
         assign ctl_pre[gm] = steer[gm*NUM_CTL + int'(CTL_PRE)] & hits[gm][int'(CTL_PRE)];
         assign ctl_clk[gm] = steer[gm*NUM_CTL + int'(CTL_CLK)] & hits[gm][int'(CTL_CLK)];
         assign ctl_ce[gm]  = steer[gm*NUM_CTL + int'(CTL_CE)]  & hits[gm][int'(CTL_CE)];
      end
   endgenerate

   // allocation per chain
   logic [NUM_MC*CHAIN_LEN-1:0] take_all;
   logic [NUM_MC-1:0]           claimed_all;
   logic [NUM_CHAIN-1:0]        chain_err;

   generate
      for (gc = 0; gc < NUM_CHAIN; gc++) begin : g_chain
         pta_chain #(.CHAIN_LEN(CHAIN_LEN), .MAX_BORROW(MAX_BORROW)) u_chain (
            .borrow  (borrow_cnt[gc*CHAIN_LEN*BW +: CHAIN_LEN*BW]),
            .take    (take_all[gc*CHAIN_LEN*CHAIN_LEN +: CHAIN_LEN*CHAIN_LEN]),
            .claimed (claimed_all[gc*CHAIN_LEN +: CHAIN_LEN]),
            .err     (chain_err[gc])
         );
      end
   endgenerate

   assign config_error = |chain_err;

   // sum formation and guards
   generate
      for (gm = 0; gm < NUM_MC; gm++) begin : g_sum
         localparam int POS   = gm % CHAIN_LEN;
         localparam int CBASE = gm - POS;
         always_comb begin
            logic acc;
            acc = claimed_all[gm] ? 1'b0 : grp[gm];
            for (int j = 0; j < CHAIN_LEN; j++) begin
               acc = acc | (take_all[gm*CHAIN_LEN + j] & grp[CBASE + j]);
            end
            sum_out[gm] = acc;
         end

         always_comb begin
            // R5: a lender that borrows nothing is silent
            if (claimed_all[gm] && borrow_cnt[gm*BW +: BW] == '0)
               a_r5_lender_quiet: assert (sum_out[gm] == 1'b0);
            // R6: reaching past the chain start is flagged
            if (int'(borrow_cnt[gm*BW +: BW]) > POS)
               a_r6_overreach_flag: assert (config_error);
            // R2: an uninvolved macrocell sums only its own group
            if (!claimed_all[gm] && borrow_cnt[gm*BW +: BW] == '0)
               a_r2_isolated_sum: assert (sum_out[gm] == grp[gm]);
            // R8: all four steered away leaves only the last term
            if (steer[gm*NUM_CTL +: NUM_CTL] == '1 && !claimed_all[gm] &&
                borrow_cnt[gm*BW +: BW] == '0 && !hits[gm][PT_PER_MC-1])
               a_r8_steered_out: assert (sum_out[gm] == 1'b0);
         end

         if (POS > 0) begin : g_pull
            // R4: a legal borrow of at least one group sees the neighbour
            always_comb begin
               if (!config_error && borrow_cnt[gm*BW +: BW] != '0 && grp[gm-1])
                  a_r4_borrow_pulls: assert (sum_out[gm]);
            end
         end
      end
   endgenerate
endmodule

// File: tb/pt_alloc_block_test.sv
module pt_alloc_block_test;
   localparam int N_IN = 8;
   localparam int NUM_MC = 16;
   localparam int PT = 5;
   localparam int LIT_W = 2*N_IN + NUM_MC;
   localparam int BW = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [N_IN-1:0]           arr_in;
   logic [NUM_MC*PT*LIT_W-1:0] term_fuse;
   logic [NUM_MC*2*N_IN-1:0]   shx_fuse;
   logic [NUM_MC*BW-1:0]       borrow_cnt;
   logic [NUM_MC*4-1:0]        steer;
   logic [NUM_MC-1:0] sum_out, ctl_clr, ctl_pre, ctl_clk, ctl_ce;
   logic config_error;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   pt_alloc_block uut (
      .arr_in(arr_in), .term_fuse(term_fuse), .shx_fuse(shx_fuse),
      .borrow_cnt(borrow_cnt), .steer(steer), .sum_out(sum_out),
      .ctl_clr(ctl_clr), .ctl_pre(ctl_pre), .ctl_clk(ctl_clk), .ctl_ce(ctl_ce),
      .config_error(config_error)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic clear_cfg();
      term_fuse = '0; shx_fuse = '0; borrow_cnt = '0; steer = '0; arr_in = '0;
   endtask

   task automatic set_term(input int m, input int t, input int lit);
      term_fuse[(m*PT + t)*LIT_W + lit] = 1'b1;
   endtask

   task automatic settle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      clear_cfg(); arr_in = 8'hA5; settle();
      check("R9", "sum idle", 32'(sum_out), 0);
      check("R9", "ctl idle", 32'({ctl_clr, ctl_pre, ctl_clk, ctl_ce}), 0);
      check("R9", "err idle", 32'(config_error), 0);
   endtask

   task automatic t_own_terms();
      clear_cfg();
      set_term(3, 2, 0); set_term(3, 2, 3);   // R1: in0 & ~in1
      arr_in = 8'h01; settle();
      check("R1", "term in0&~in1 true", 32'(sum_out), 32'h0008);
      arr_in = 8'h03; settle();
      check("R1", "term in0&~in1 false", 32'(sum_out), 0);
      set_term(3, 4, 5);                      // R2: second term ~in2
      arr_in = 8'h03; settle();
      check("R2", "OR of own terms", 32'(sum_out), 32'h0008);
   endtask

   task automatic t_steer();
      clear_cfg();
      set_term(3, 2, 0); steer[3*4 + 2] = 1'b1;  // R8: term 2 -> clock
      arr_in = 8'h01; settle();
      check("R8", "steered term off sum", 32'(sum_out), 0);
      check("R8", "clock control", 32'(ctl_clk), 32'h0008);
      check("R8", "other controls", 32'({ctl_clr, ctl_pre, ctl_ce}), 0);
   endtask

   task automatic t_shared();
      clear_cfg();
      shx_fuse[5*2*N_IN + 0] = 1'b1;           // R3: expander 5 = ~in0
      set_term(10, 0, 2*N_IN + 5);
      set_term(1, 4, 2*N_IN + 5);
      arr_in = 8'h00; settle();
      check("R3", "shared expander high", 32'(sum_out), 32'h0402);
      arr_in = 8'h01; settle();
      check("R3", "shared expander low", 32'(sum_out), 0);
   endtask

   task automatic t_borrow();
      clear_cfg();
      set_term(12, 1, 0);                      // in0
      arr_in = 8'h01; settle();
      check("R2", "owner before lending", 32'(sum_out), 32'h1000);
      borrow_cnt[15*BW +: BW] = 2'd3; settle();
      check("R4", "mc15 takes group 12", 32'(sum_out), 32'h8000);
      check("R5", "mc12 silent", 32'(sum_out[12]), 0);
      check("R9", "legal borrow no error", 32'(config_error), 0);
   endtask

   task automatic t_boundary();
      clear_cfg();
      set_term(7, 0, 0);
      borrow_cnt[8*BW +: BW] = 2'd1;
      arr_in = 8'h01; settle();
      check("R6", "first of chain borrowing flagged", 32'(config_error), 1);
      check("R6", "no crossing", 32'(sum_out), 32'h0080);
      clear_cfg();
      set_term(8, 0, 0);
      borrow_cnt[9*BW +: BW] = 2'd2;
      arr_in = 8'h01; settle();
      check("R6", "overreach flagged", 32'(config_error), 1);
      check("R6", "clipped run", 32'(sum_out), 32'h0200);
   endtask

   task automatic t_double();
      clear_cfg();
      borrow_cnt[3*BW +: BW] = 2'd2;
      borrow_cnt[2*BW +: BW] = 2'd1;
      settle();
      check("R7", "double claim flagged", 32'(config_error), 1);
      borrow_cnt[3*BW +: BW] = 2'd1; settle();
      check("R9", "chained distinct claims legal", 32'(config_error), 0);
   endtask

   initial begin
      clear_cfg();
      repeat (2) @(negedge clk);
      t_reset();
      t_own_terms();
      t_steer();
      t_shared();
      t_borrow();
      t_boundary();
      t_double();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule